// File: doc/BRIEF.md
# Sum-of-Products Trigger Decision with Prescale

This block turns a vector of input condition bits into a set of trigger decisions. Each decision output has a condition held in configuration registers. The condition is an OR of product terms. Every term has a mask of inputs that must be high, a mask of inputs that must be low, and a flag that enables the term. An output with no enabled terms fires on every event.

Each output that fires then passes through its own prescale counter. The counter lets through only every Nth firing, where N is that output's programmable factor. The block therefore returns two vectors: the raw decisions and the prescaled decisions. Each vector carries one extra summary bit that is set when any of its outputs is set.

Both vectors are captured on one clock edge for each event strobe and hold their value until the next strobe. A single-cycle write port loads the masks, the enable flags and the prescale factors.

Top module: `sop_trig_decide`

## Requirements
- R1: An output with none of its terms enabled fires on every event, whatever the input bits are.
- R2: A term holds when every input bit in its must-be-high mask is 1 and every input bit in its must-be-low mask is 0. An output fires when at least one of its enabled terms holds.
- R3: A term whose enable flag is clear has no effect on its output, even if its masks match the inputs.
- R4: With a prescale factor of 0, the prescaled bit of that output never asserts.
- R5: With a prescale factor of 1, the prescaled bit equals the raw bit on every event.
- R6: With a factor N greater than 1, the prescaled bit asserts on the Nth, 2Nth, 3Nth, ... event in which that output fires. Events in which the output does not fire do not advance its count.
- R7: A prescaled bit is never set unless the raw bit of the same output is set in the same result.
- R8: Writing an output's prescale factor restarts that output's count from zero.
- R9: Bit N_OUT of the raw vector is the OR of raw bits 0..N_OUT-1. Bit N_OUT of the prescaled vector is the OR of prescaled bits 0..N_OUT-1.
- R10: Output i is placed at result bit i, which is word i/32, bit i mod 32. All result bits above N_OUT are 0.
- R11: The results change only on the clock edge at which evt_strobe is high, and they take the value computed from cond_in and the configuration at that edge. Between strobes the results hold.
- R12: Reset clears both results, all masks, all enable flags, all prescale factors and all counts.
- R13: A write address is {kind[1:0], output[OUT_W-1:0], term[TERM_W-1:0]}. The kinds are: 0 for the must-be-high mask, 1 for the must-be-low mask, 2 for the term enable (data bit 0), and 3 for the prescale factor (data bits PS_W-1:0, term field ignored). A write that names an output index of N_OUT or above changes nothing.

Default widths: OUT_W = 4 and TERM_W = 2, so the write address is 8 bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 2+OUT_W+TERM_W | Write address {kind, output, term} |
| cfg_wdata | input | max(N_IN,PS_W) | Write data |
| evt_strobe | input | 1 | Event strobe; results are captured at this edge |
| cond_in | input | N_IN | Input condition bits |
| raw_bits | output | RES_W | Raw decisions, summary bit, zero padding |
| ps_bits | output | RES_W | Prescaled decisions, summary bit, zero padding |

## Verification
The bound checker checks on every cycle the relations that hold regardless of configuration:
- the prescaled vector is a subset of the raw vector;
- each summary bit agrees with the bits below it;
- the padding bits are zero;
- the results hold when no strobe is seen;
- the results are cleared after reset.

Only the bench scenarios can show that a particular condition or prescale factor gives the right answer. These scenarios cover:
- outputs with no enabled terms;
- masks that are disabled but would match;
- factors 0, 1 and N, including counts that skip events where the output does not fire;
- a factor rewrite that restarts the count;
- writes to out-of-range output indices.

// File: rtl/sop_trig_pkg.sv
// Shared definitions for the sum-of-products trigger decision block.
// Assumes the write address carries a 2-bit kind field in its top bits.
package sop_trig_pkg;

    // What a configuration write targets.
    typedef enum logic [1:0] {
        CFG_HI_MASK = 2'd0,
        CFG_LO_MASK = 2'd1,
        CFG_ENABLE  = 2'd2,
        CFG_FACTOR  = 2'd3
    } cfg_kind_e;

endpackage

// File: rtl/sop_cond_unit.sv
// One output's condition: N_TERMS product terms, each with a must-be-high
// mask, a must-be-low mask and an enable flag, all held in registers.
// The output fires when no term is enabled, or when any enabled term holds.
// Assumes that at most one of the write enables is high in a cycle.
module sop_cond_unit #(
    parameter int N_IN    = 16,
    parameter int N_TERMS = 4,
    parameter int TERM_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic              wr_en,
    input  logic [TERM_W-1:0] wr_term,
    input  logic [N_IN-1:0]   wr_data,
    input  logic [N_IN-1:0]   cond_in,
    output logic              fire
);

    logic [N_TERMS-1:0] term_on;
    logic [N_TERMS-1:0] term_hit;

    for (genvar t = 0; t < N_TERMS; t++) begin : g_term
        logic [N_IN-1:0] hi_mask;
        logic [N_IN-1:0] lo_mask;
        logic            sel;

        assign sel = (wr_term == TERM_W'(t));

        // Hold the masks and the enable flag of this term.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hi_mask    <= '0;
                lo_mask    <= '0;
                term_on[t] <= 1'b0;
            end else if (sel) begin
                if (wr_hi) hi_mask    <= wr_data;
                if (wr_lo) lo_mask    <= wr_data;
                if (wr_en) term_on[t] <= wr_data[0];
            end
        end

        // The term holds when every required-high bit is set and every required-low bit is clear.
        always_comb begin
            term_hit[t] = term_on[t]
                        && ((cond_in & hi_mask) == hi_mask)
                        && ((cond_in & lo_mask) == '0);
        end
    end

    // OR of the terms; an output with no enabled terms always fires.
    always_comb begin
        fire = (term_on == '0) || (|term_hit);
    end

endmodule

// File: rtl/sop_ps_gate.sv
// Per-output prescaler. It holds the factor and a count of the events in
// which the output fired. Factor 0 blocks every event, factor 1 passes
// every event, and factor N passes every Nth fired event.
// Assumes evt marks the edge at which the parent captures pass.
module sop_ps_gate #(
    parameter int PS_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fac_we,
    input  logic [PS_W-1:0] fac_data,
    input  logic            evt,
    input  logic            raw,
    output logic            pass
);

    logic [PS_W-1:0] factor;
    logic [PS_W-1:0] count;
    logic [PS_W-1:0] count_nxt;

    // Decide whether this fired event is accepted, and compute the next count.
    always_comb begin
        pass      = 1'b0;
        count_nxt = count;
        if (raw) begin
            if (factor == PS_W'(1)) begin
                pass = 1'b1;
            end else if (factor != '0) begin
                if (count == factor - PS_W'(1)) begin
                    pass      = 1'b1;
                    count_nxt = '0;
                end else begin
                    count_nxt = count + PS_W'(1);
                end
            end
        end
    end

    // Load the factor (restarting the count) or advance the count on an event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            factor <= '0;
            count  <= '0;
        end else if (fac_we) begin
            factor <= fac_data;
            count  <= '0;
        end else if (evt) begin
            count <= count_nxt;
        end
    end

endmodule

// File: rtl/sop_trig_decide.sv
// Sum-of-products trigger decision with per-output prescale.
// It decodes configuration writes, evaluates N_OUT conditions, prescales
// each fired output, and captures both vectors plus their summary bits once
// per event strobe. The result vectors are padded to whole 32-bit words.
// Assumes no factor write is issued in the same cycle as an event strobe.
module sop_trig_decide #(
    parameter int N_IN    = 16,
    parameter int N_OUT   = 13,
    parameter int N_TERMS = 4,
    parameter int PS_W    = 8
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  cfg_we,
    input  logic [2+((N_OUT>1)?$clog2(N_OUT):1)
                    +((N_TERMS>1)?$clog2(N_TERMS):1)-1:0] cfg_addr,
    input  logic [((N_IN>PS_W)?N_IN:PS_W)-1:0]    cfg_wdata,
    input  logic                                  evt_strobe,
    input  logic [N_IN-1:0]                       cond_in,
    output logic [((N_OUT+32)/32)*32-1:0]         raw_bits,
    output logic [((N_OUT+32)/32)*32-1:0]         ps_bits
);
    import sop_trig_pkg::*;

    localparam int OUT_W  = (N_OUT > 1) ? $clog2(N_OUT) : 1;
    localparam int TERM_W = (N_TERMS > 1) ? $clog2(N_TERMS) : 1;
    localparam int ADDR_W = 2 + OUT_W + TERM_W;
    localparam int RES_W  = ((N_OUT + 32) / 32) * 32;

    cfg_kind_e         kind;
    logic [OUT_W-1:0]  out_sel;
    logic [TERM_W-1:0] term_sel;
    logic [N_OUT-1:0]  raw_now;
    logic [N_OUT-1:0]  ps_now;

    // Split the write address into its fields.
    always_comb begin
        kind     = cfg_kind_e'(cfg_addr[ADDR_W-1 -: 2]);
        out_sel  = cfg_addr[TERM_W +: OUT_W];
        term_sel = cfg_addr[TERM_W-1:0];
    end

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        logic hit;
        assign hit = cfg_we && (out_sel == OUT_W'(o));

        sop_cond_unit #(
            .N_IN   (N_IN),
            .N_TERMS(N_TERMS),
            .TERM_W (TERM_W)
        ) u_cond (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_hi  (hit && (kind == CFG_HI_MASK)),
            .wr_lo  (hit && (kind == CFG_LO_MASK)),
            .wr_en  (hit && (kind == CFG_ENABLE)),
            .wr_term(term_sel),
            .wr_data(cfg_wdata[N_IN-1:0]),
            .cond_in(cond_in),
            .fire   (raw_now[o])
        );

        sop_ps_gate #(
            .PS_W(PS_W)
        ) u_ps (
            .clk     (clk),
            .rst_n   (rst_n),
            .fac_we  (hit && (kind == CFG_FACTOR)),
            .fac_data(cfg_wdata[PS_W-1:0]),
            .evt     (evt_strobe),
            .raw     (raw_now[o]),
            .pass    (ps_now[o])
        );
    end

    // Capture both vectors, with their summary bits, on each event strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_bits <= '0;
            ps_bits  <= '0;
        end else if (evt_strobe) begin
            raw_bits <= RES_W'({|raw_now, raw_now});
            ps_bits  <= RES_W'({|ps_now, ps_now});
        end
    end

endmodule

// File: rtl/sop_trig_decide_chk.sv
// Checker for sop_trig_decide: relations between the result ports that
// hold for any configuration. Attached to the top module by bind.
module sop_trig_decide_chk #(
    parameter int N_OUT = 13,
    parameter int RES_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             evt_strobe,
    input logic [RES_W-1:0] raw_bits,
    input logic [RES_W-1:0] ps_bits
);

    p_ps_within_raw_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ps_bits & ~raw_bits) == '0);

    p_summary_raw_r9: assert property (@(posedge clk) disable iff (!rst_n)
        raw_bits[N_OUT] == (|raw_bits[N_OUT-1:0]));

    p_summary_ps_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ps_bits[N_OUT] == (|ps_bits[N_OUT-1:0]));

    p_pad_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((raw_bits >> (N_OUT + 1)) == '0) && ((ps_bits >> (N_OUT + 1)) == '0));

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(evt_strobe)) |-> ($stable(raw_bits) && $stable(ps_bits)));

    p_reset_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> ((raw_bits == '0) && (ps_bits == '0)));

endmodule

bind sop_trig_decide sop_trig_decide_chk #(
    .N_OUT(N_OUT),
    .RES_W(RES_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_strobe(evt_strobe),
    .raw_bits  (raw_bits),
    .ps_bits   (ps_bits)
);

// File: tb/sop_trig_decide_test.sv
module sop_trig_decide_test;
    localparam int N_IN = 16, N_OUT = 13, N_TERMS = 4, PS_W = 8;
    localparam int OUT_W = 4, TERM_W = 2, RES_W = 32, CFG_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [7:0]        cfg_addr = '0;
    logic [CFG_W-1:0]  cfg_wdata = '0;
    logic              evt_strobe = 1'b0;
    logic [N_IN-1:0]   cond_in = '0;
    logic [RES_W-1:0]  raw_bits, ps_bits;

    sop_trig_decide uut (.*);

    always #10 clk = ~clk;

    int n_chk = 0, n_fail = 0;

    // Reference model state
    logic [N_IN-1:0] m_hi [N_OUT][N_TERMS];
    logic [N_IN-1:0] m_lo [N_OUT][N_TERMS];
    logic            m_on [N_OUT][N_TERMS];
    int              m_fac [N_OUT];
    int              m_cnt [N_OUT];
    logic [RES_W-1:0] last_raw = '0, last_ps = '0;

    task automatic model_reset();
        for (int o = 0; o < N_OUT; o++) begin
            m_fac[o] = 0; m_cnt[o] = 0;
            for (int t = 0; t < N_TERMS; t++) begin
                m_hi[o][t] = '0; m_lo[o][t] = '0; m_on[o][t] = 1'b0;
            end
        end
        last_raw = '0; last_ps = '0;
    endtask

    function automatic logic cond_fire(int o, logic [N_IN-1:0] inp);
        logic any_on = 1'b0, hit = 1'b0;
        for (int t = 0; t < N_TERMS; t++) begin
            if (m_on[o][t]) begin
                any_on = 1'b1;
                if (((inp & m_hi[o][t]) == m_hi[o][t]) && ((inp & m_lo[o][t]) == '0)) hit = 1'b1;
            end
        end
        return !any_on || hit;
    endfunction

    task automatic chk(string tag, logic [RES_W-1:0] act, logic [RES_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(int kind, int o, int t, logic [CFG_W-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_addr = {kind[1:0], o[OUT_W-1:0], t[TERM_W-1:0]};
        cfg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
        if (o < N_OUT) begin
            case (kind)
                0: m_hi[o][t] = d;
                1: m_lo[o][t] = d;
                2: m_on[o][t] = d[0];
                default: begin m_fac[o] = int'(d[PS_W-1:0]); m_cnt[o] = 0; end
            endcase
        end
    endtask

    task automatic do_evt(logic [N_IN-1:0] inp, string tr, string tp);
        logic [RES_W-1:0] er = '0, ep = '0;
        @(negedge clk);
        evt_strobe = 1'b1; cond_in = inp;
        for (int o = 0; o < N_OUT; o++) begin
            er[o] = cond_fire(o, inp);
            if (er[o]) begin
                if (m_fac[o] == 1) ep[o] = 1'b1;
                else if (m_fac[o] > 1) begin
                    if (m_cnt[o] == m_fac[o] - 1) begin ep[o] = 1'b1; m_cnt[o] = 0; end
                    else m_cnt[o]++;
                end
            end
        end
        er[N_OUT] = |er[N_OUT-1:0];
        ep[N_OUT] = |ep[N_OUT-1:0];
        @(posedge clk);
        @(negedge clk);
        evt_strobe = 1'b0;
        chk(tr, raw_bits, er);
        chk(tp, ps_bits, ep);
        chk("R7", ps_bits & ~raw_bits, '0);
        chk("R9", {31'd0, raw_bits[N_OUT]}, {31'd0, |raw_bits[N_OUT-1:0]});
        chk("R10", raw_bits >> (N_OUT + 1), '0);
        last_raw = er; last_ps = ep;
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12", raw_bits, '0);
        chk("R12", ps_bits, '0);
        // R1 and R4: the reset configuration has no enabled terms and factor 0
        do_evt(16'h0000, "R1", "R4");
        do_evt(16'hFFFF, "R1", "R4");
        // R2: AND within a term, OR across terms
        wr(0, 0, 0, 16'h0009); wr(1, 0, 0, 16'h0020); wr(2, 0, 0, 16'h0001);
        do_evt(16'h0009, "R2", "R4");
        do_evt(16'h0029, "R2", "R4");
        do_evt(16'h0008, "R2", "R4");
        wr(0, 0, 1, 16'h0100); wr(2, 0, 1, 16'h0001);
        do_evt(16'h0100, "R2", "R4");
        // R3: a disabled term whose masks match has no effect
        wr(0, 1, 2, 16'h0002); wr(0, 1, 3, 16'h8000); wr(2, 1, 3, 16'h0001);
        do_evt(16'h0002, "R3", "R4");
        wr(2, 1, 2, 16'h0001);
        do_evt(16'h0002, "R3", "R4");
        // R5: factor 1
        wr(3, 2, 0, 16'h0001);
        do_evt(16'h0000, "R5", "R5");
        do_evt(16'h1234, "R5", "R5");
        // R6: factor 3 on an always-firing output, factor 2 on a conditional one
        wr(3, 3, 0, 16'h0003);
        wr(0, 4, 0, 16'h0001); wr(2, 4, 0, 16'h0001); wr(3, 4, 0, 16'h0002);
        for (int i = 0; i < 8; i++) do_evt(N_IN'(i % 3 == 0), "R6", "R6");
        // R8: a factor rewrite restarts the count; nonzero term field ignored (R13)
        do_evt(16'h0000, "R8", "R8");
        wr(3, 3, 3, 16'h0003);
        for (int i = 0; i < 4; i++) do_evt(16'h0001, "R8", "R8");
        // R13: writes to out-of-range output indices change nothing
        wr(2, 13, 0, 16'h0001); wr(0, 14, 1, 16'hFFFF); wr(3, 15, 0, 16'h0001);
        do_evt(16'h0000, "R13", "R13");
        // R11: results hold between strobes while inputs change
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            cond_in = N_IN'($urandom);
            @(negedge clk);
            chk("R11", raw_bits, last_raw);
            chk("R11", ps_bits, last_ps);
        end
        // Random mix of configuration writes and events
        for (int i = 0; i < 600; i++) begin
            if ($urandom % 4 == 0) begin
                int k = $urandom % 4;
                logic [CFG_W-1:0] d;
                if (k == 3) d = CFG_W'($urandom % 5);
                else if (k == 2) d = CFG_W'($urandom % 2);
                else d = CFG_W'($urandom & $urandom & $urandom);
                wr(k, $urandom % 16, $urandom % 4, d);
            end else begin
                do_evt(N_IN'($urandom), "R2", "R6");
            end
        end
        // R12: reset mid-run clears configuration and counts
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        @(negedge clk);
        chk("R12", raw_bits, '0);
        do_evt(16'h5555, "R12", "R12");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule